// File: doc/BRIEF.md
# Deadline Countdown Register Bank

This block keeps a bank of cycle countdown registers for a processor pipeline and executes deadline instructions against them. Each instruction names one register and carries a cycle count. When the named register has already run out (reads zero), the count is written at once and the instruction retires that cycle. When the register is still counting, the instruction is parked inside the block and the pipeline is held through the `stall` output. The parked instruction retires as soon as that register reaches zero.

Every register counts down by one per clock until it reaches zero, and it then stays there. Code marks a timed region in two steps. It first issues a start instruction with the required cycle count. It then issues a closing instruction with count zero on the same register. Because the closing instruction cannot retire before the countdown runs out, the region takes at least the requested number of cycles. This sets a floor on execution time rather than acting as a timeout. If a closing instruction arrives after its register has already sat at zero for a cycle or more, the block sets a sticky per-register overrun flag, which a clear strobe can reset. A debug port returns any register's live count without delay.

Top module: `deadline_timer_bank`

## Requirements
- R1: After reset, every count reads 0, `stall` and `issue_done` are low and all `overrun` bits are 0.
- R2: A register holding a nonzero count, and not being written, drops by exactly one on each clock. A register at zero stays at zero and never wraps.
- R3: An instruction whose register reads zero in its issue cycle retires in that cycle: `issue_done` is high, `stall` is low, and the debug port shows the new count from the next cycle on.
- R4: An instruction issued to a register whose count is N (N > 0) holds `stall` high for N cycles, starting in the issue cycle. `issue_done` is high in the cycle after the last stall cycle, and the new count is visible from the cycle after that.
- R5: While an instruction is parked, `issue_valid` and the index and value that come with it are ignored: no register is written from them.
- R6: A start instruction with count V, followed in the next cycle by a closing instruction (count 0) on the same register, stalls the closing instruction for exactly V cycles.
- R7: `overrun[i]` is set when a newly issued instruction with count 0 targets register i and register i read zero both in that cycle and in the cycle before. It is not set when the register only just reached zero, when the count is nonzero, or when a parked instruction retires.
- R8: A pulse on `ovr_clr_valid` clears only the `overrun` bit selected by `ovr_clr_idx`. If a set on the same register falls in the same cycle, the set wins. A set bit otherwise stays set.
- R9: `dbg_count` shows the count of the register selected by `dbg_idx` in the same cycle, with no register in between.
- R10: Registers that are not named by the parked instruction keep counting down while the pipeline is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | A deadline instruction is presented |
| issue_idx | input | IDX_W (3) | Register named by the instruction |
| issue_val | input | CNT_W (32) | Cycle count to load |
| stall | output | 1 | Pipeline must hold: the current instruction waits on a running register |
| issue_done | output | 1 | The load takes effect at the coming clock edge |
| ovr_clr_valid | input | 1 | Clear strobe for one overrun flag |
| ovr_clr_idx | input | IDX_W (3) | Register whose overrun flag is cleared |
| overrun | output | NUM_TMR (8) | Sticky overrun flags, one per register |
| dbg_idx | input | IDX_W (3) | Register selected for debug read |
| dbg_count | output | CNT_W (32) | Live count of the selected register |

## Verification
In one cycle, a late closing instruction can set a register's overrun flag while the clear strobe names that same register. The bench provokes this in two steps. It first makes a register overrun. It then, in a single cycle, issues a second late closing instruction to that register and pulses the clear strobe with the same index. The flag must read set in the next cycle. The bench then checks that a clear aimed at another register leaves the flag alone, and that a clear on its own empties it.

// File: rtl/deadline_timer_bank.sv
`timescale 1ns/1ps
module deadline_timer_bank #(
  parameter int NUM_TMR = 8,
  parameter int CNT_W = 32,
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [IDX_W-1:0]   issue_idx,
  input  logic [CNT_W-1:0]   issue_val,
  output logic               stall,
  output logic               issue_done,
  input  logic               ovr_clr_valid,
  input  logic [IDX_W-1:0]   ovr_clr_idx,
  output logic [NUM_TMR-1:0] overrun,
  input  logic [IDX_W-1:0]   dbg_idx,
  output logic [CNT_W-1:0]   dbg_count
);

  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_TMR-1:0] zero_now, zero_prev_q, ovr_q, ovr_d;

  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [CNT_W-1:0] pend_val_q;

  logic             req_v, req_zero, fire, late_end;
  logic [IDX_W-1:0] req_idx;
  logic [CNT_W-1:0] req_val;

  assign req_v    = pend_q | issue_valid;
  assign req_idx  = pend_q ? pend_idx_q : issue_idx;
  assign req_val  = pend_q ? pend_val_q : issue_val;
  assign req_zero = zero_now[req_idx];
  assign fire     = req_v & req_zero;
  assign late_end = issue_valid & ~pend_q & (issue_val == '0)
                  & zero_now[issue_idx] & zero_prev_q[issue_idx];

  assign stall      = req_v & ~req_zero;
  assign issue_done = fire;
  assign overrun    = ovr_q;
  assign dbg_count  = cnt_q[dbg_idx];

  always_comb begin
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    for (int i = 0; i < NUM_TMR; i++) begin
      zero_now[i] = (cnt_q[i] == '0);
      if (fire && req_idx == IDX_W'(i))
        cnt_d[i] = req_val;
      else if (!zero_now[i])
        cnt_d[i] = cnt_q[i] - 1'b1;
      if (ovr_clr_valid && ovr_clr_idx == IDX_W'(i))
        ovr_d[i] = 1'b0;
      if (late_end && issue_idx == IDX_W'(i))
        ovr_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      zero_prev_q <= '0;
      ovr_q       <= '0;
    end else begin
      cnt_q       <= cnt_d;
      zero_prev_q <= zero_now;
      ovr_q       <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_val_q <= '0;
    end else if (pend_q) begin
      if (req_zero) pend_q <= 1'b0;
    end else if (issue_valid && !req_zero) begin
      pend_q     <= 1'b1;
      pend_idx_q <= issue_idx;
      pend_val_q <= issue_val;
    end
  end

endmodule

// File: rtl/deadline_timer_bank_chk.sv
`timescale 1ns/1ps
module deadline_timer_bank_chk #(
  parameter int NUM_TMR = 8,
  parameter int CNT_W = 32,
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          stall,
  input logic                          issue_done,
  input logic [IDX_W-1:0]              req_idx,
  input logic [CNT_W-1:0]              req_val,
  input logic                          pend_q,
  input logic [IDX_W-1:0]              pend_idx_q,
  input logic [CNT_W-1:0]              pend_val_q,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_TMR-1:0]            ovr_q,
  input logic                          ovr_clr_valid,
  input logic [IDX_W-1:0]              ovr_clr_idx
);

  a_r3_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
    issue_done |=> cnt_q[$past(req_idx)] == $past(req_val));

  a_r4_last_stall_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cnt_q[req_idx] == CNT_W'(1)) |=> issue_done);

  a_r5_parked_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && stall) |=> (pend_q && $stable(pend_idx_q) && $stable(pend_val_q)));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_per
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] != '0 && !(issue_done && req_idx == IDX_W'(i)))
        |=> cnt_q[i] == $past(cnt_q[i]) - CNT_W'(1));

    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == '0 && !(issue_done && req_idx == IDX_W'(i))) |=> cnt_q[i] == '0);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q[i] && !(ovr_clr_valid && ovr_clr_idx == IDX_W'(i))) |=> ovr_q[i]);
  end

endmodule

bind deadline_timer_bank deadline_timer_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/deadline_timer_bank_tb.sv
`timescale 1ns/1ps
module deadline_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_idx = '0;
  logic [31:0] issue_val = '0;
  logic        stall, issue_done;
  logic        ovr_clr_valid = 1'b0;
  logic [2:0]  ovr_clr_idx = '0;
  logic [7:0]  overrun;
  logic [2:0]  dbg_idx = '0;
  logic [31:0] dbg_count;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  deadline_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_val(issue_val),
    .stall(stall), .issue_done(issue_done),
    .ovr_clr_valid(ovr_clr_valid), .ovr_clr_idx(ovr_clr_idx),
    .overrun(overrun), .dbg_idx(dbg_idx), .dbg_count(dbg_count)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] idx, output logic [31:0] v);
    dbg_idx = idx;
    #0.1;
    v = dbg_count;
  endtask

  task automatic drive(logic vld, logic [2:0] idx, logic [31:0] val);
    issue_valid = vld;
    issue_idx = idx;
    issue_val = val;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    #1;
    for (int i = 0; i < 8; i++) begin
      peek(3'(i), v);
      check("R1 count after reset", v, 0);
    end
    check("R1 stall after reset", 32'(stall), 0);
    check("R1 done after reset", 32'(issue_done), 0);
    check("R1 overrun after reset", 32'(overrun), 0);
  endtask

  task automatic t_load_idle();
    logic [31:0] v;
    @(negedge clk); drive(1, 2, 5); #1;
    check("R3 no stall on idle register", 32'(stall), 0);
    check("R3 done in issue cycle", 32'(issue_done), 1);
    @(negedge clk); drive(0, 0, 0); #1;
    peek(2, v); check("R3 R9 loaded count", v, 5);
    @(negedge clk); #1;
    peek(2, v); check("R2 decrement", v, 4);
    for (int k = 0; k < 4; k++) @(negedge clk);
    #1; peek(2, v); check("R2 reaches zero", v, 0);
    @(negedge clk); #1;
    peek(2, v); check("R2 no wrap", v, 0);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    @(negedge clk); drive(1, 1, 4); #1;
    check("R3 load reg1", 32'(issue_done), 1);
    @(negedge clk); drive(1, 3, 10);
    @(negedge clk); drive(1, 1, 7); #1;
    check("R4 stall cycle 1", 32'(stall), 1);
    check("R4 no done cycle 1", 32'(issue_done), 0);
    @(negedge clk); drive(1, 5, 9); #1;
    check("R4 stall cycle 2", 32'(stall), 1);
    check("R5 no done for new issue", 32'(issue_done), 0);
    peek(3, v); check("R10 other register counts", v, 9);
    @(negedge clk); drive(0, 0, 0); #1;
    check("R4 stall cycle 3", 32'(stall), 1);
    @(negedge clk); #1;
    check("R4 stall released", 32'(stall), 0);
    check("R4 done after wait", 32'(issue_done), 1);
    @(negedge clk); #1;
    check("R4 done is a pulse", 32'(issue_done), 0);
    peek(1, v); check("R4 new count loaded", v, 7);
    peek(5, v); check("R5 ignored issue wrote nothing", v, 0);
  endtask

  task automatic t_region();
    logic [31:0] v;
    int n;
    @(negedge clk); drive(1, 4, 6); #1;
    check("R6 start retires", 32'(issue_done), 1);
    @(negedge clk); drive(1, 4, 0); #1;
    check("R6 end stalls", 32'(stall), 1);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); drive(0, 0, 0); #1;
      if (!stall) break;
      n++;
    end
    check("R6 stall cycles equal requirement", 32'(n), 6);
    check("R6 end retires", 32'(issue_done), 1);
    @(negedge clk); #1;
    peek(4, v); check("R6 count after region", v, 0);
    check("R7 parked end sets no overrun", 32'(overrun[4]), 0);
  endtask

  task automatic t_overrun();
    @(negedge clk); drive(1, 6, 0); #1;
    check("R7 late end retires", 32'(issue_done), 1);
    @(negedge clk); drive(0, 0, 0); #1;
    check("R7 late end sets overrun", 32'(overrun[6]), 1);
    @(negedge clk); drive(1, 7, 2);
    @(negedge clk); drive(0, 0, 0);
    @(negedge clk);
    @(negedge clk); drive(1, 7, 0); #1;
    check("R7 exact end retires", 32'(issue_done), 1);
    @(negedge clk); drive(0, 0, 0); #1;
    check("R7 exact end no overrun", 32'(overrun[7]), 0);
    @(negedge clk); drive(1, 0, 3);
    @(negedge clk); drive(0, 0, 0); #1;
    check("R7 nonzero value no overrun", 32'(overrun[0]), 0);
    ovr_clr_valid = 1; ovr_clr_idx = 6;
    @(negedge clk); ovr_clr_valid = 0; #1;
    check("R8 clear strobe", 32'(overrun[6]), 0);
    drive(1, 2, 0);
    @(negedge clk); drive(0, 0, 0); #1;
    check("R7 overrun reg2", 32'(overrun[2]), 1);
    drive(1, 2, 0); ovr_clr_valid = 1; ovr_clr_idx = 2;
    @(negedge clk); drive(0, 0, 0); ovr_clr_valid = 0; #1;
    check("R8 set wins over clear", 32'(overrun[2]), 1);
    ovr_clr_valid = 1; ovr_clr_idx = 6;
    @(negedge clk); ovr_clr_valid = 0; #1;
    check("R8 clear touches only its index", 32'(overrun[2]), 1);
    ovr_clr_valid = 1; ovr_clr_idx = 2;
    @(negedge clk); ovr_clr_valid = 0; #1;
    check("R8 clear reg2", 32'(overrun), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_idle();
    t_stall();
    t_region();
    t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule